// File: doc/BRIEF.md
# Odd-Line Inversion Link Codec

This block sits at both ends of a point-to-point on-chip link of `W` wires. It lowers the energy spent charging the capacitance between neighbouring wires. The transmit half accepts a payload of `W-1` bits with a valid strobe. For each accepted flit it chooses between two forms: send the payload as it is, or send it with every odd-numbered wire complemented. The topmost wire carries a flag that records the choice. The receive half reads that flag and undoes the complement, so the payload comes back unchanged.

To make the choice, the encoder looks at every pair of neighbouring wires. It compares the candidate word, which is the payload with a 0 in the flag position, against the word it last put on the link, flag included. A pair counts as helped when complementing the odd wire of that pair would lower the pair's coupling cost. The cost is 1 when one wire toggles while its neighbour holds, 2 when both toggle in opposite directions, and 0 when both toggle the same way or neither moves. When more than half of the `W-1` pairs are helped, the encoder inverts. `W` must be even, so the flag wire is itself an odd wire and reads 1 exactly on inverted flits.

Top module: `link_oddinv_codec`

## Requirements
- R1: While `rst_n` is low, `lnk_word`, `lnk_valid`, `dec_payload` and `dec_out_valid` are all zero, whatever the other inputs do.
- R2: One clock edge after `enc_valid` is sampled high, `lnk_valid` is high and `lnk_word` holds the encoded flit. After an edge where `enc_valid` is low, `lnk_valid` is low and `lnk_word` keeps its previous value.
- R3: Wire `W-1` of `lnk_word` is the inversion flag. Wires 0 to `W-2` carry the payload bit of the same index, and the even-indexed wires always carry it unchanged.
- R4: The odd-indexed payload wires carry the complement of the payload when the flag is 1, and the payload itself when the flag is 0.
- R5: A wire pair (i, i+1) counts as helped when complementing its odd wire strictly lowers the pair's cost. The cost is 1 for a lone toggle, 2 for toggles in opposite directions, and 0 for same-direction toggles or no change.
- R6: The flag of an encoded flit is 1 exactly when the number of helped pairs exceeds (W-1)/2. In particular, a candidate equal to the last transmitted word never inverts.
- R7: The comparison base is the last word sent on the link. It starts at all zeros after reset and changes only on cycles where `enc_valid` is high.
- R8: One edge after `dec_valid` is high, `dec_out_valid` is high. `dec_payload` then equals wires 0 to `W-2` of `dec_word`, with the odd-indexed bits complemented when `dec_word[W-1]` is 1. When `dec_valid` is low, `dec_out_valid` drops and `dec_payload` holds.
- R9: Feeding `lnk_word` and `lnk_valid` straight into the receive half returns every transmitted payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid | input | 1 | Payload on `enc_payload` is accepted this cycle |
| enc_payload | input | W-1 | Payload to transmit |
| lnk_valid | output | 1 | `lnk_word` holds a newly encoded flit |
| lnk_word | output | W | Encoded link word, flag on the top wire |
| dec_valid | input | 1 | `dec_word` is a received flit |
| dec_word | input | W | Received link word |
| dec_out_valid | output | 1 | `dec_payload` holds a newly decoded flit |
| dec_payload | output | W-1 | Restored payload |

## Verification
The encoded word and its flag appear one clock edge after the edge that samples `enc_valid`. The decoded payload appears one edge after `dec_valid`. With the two halves looped together, a payload comes back two edges after it was accepted. The bench changes inputs on the falling edge and reads results at the next falling edge for the encoder, and one falling edge later for the looped-back decoder. In streaming runs it holds a short history of expected words and payloads, so each result is compared in the cycle it is due. Hold behaviour is checked during idle cycles, while the payload input is driven with garbage.

// File: rtl/link_oddinv_codec.sv
module link_oddinv_codec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_valid,
  input  logic [W-2:0] enc_payload,
  output logic         lnk_valid,
  output logic [W-1:0] lnk_word,
  input  logic         dec_valid,
  input  logic [W-1:0] dec_word,
  output logic         dec_out_valid,
  output logic [W-2:0] dec_payload
);
  localparam int NPAIR = W - 1;
  localparam int CW    = $clog2(W) + 1;
  localparam int HALF  = (W - 1) / 2;

  function automatic logic [W-1:0] odd_wires();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD_LINES  = odd_wires();
  localparam logic [W-1:0] EVEN_LINES = ~ODD_LINES;

  // encoder: candidate, its odd-inverted twin, per-pair benefit
  logic [W-1:0]     cand, cand_inv;
  logic [NPAIR-1:0] helps;
  logic [CW-1:0]    help_cnt;
  logic             flip;

  assign cand     = {1'b0, enc_payload};
  assign cand_inv = cand ^ ODD_LINES;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic tl, th, tl_i, th_i;
    logic lone, opp, opp_i;
    assign tl    = lnk_word[g]   ^ cand[g];
    assign th    = lnk_word[g+1] ^ cand[g+1];
    assign tl_i  = lnk_word[g]   ^ cand_inv[g];
    assign th_i  = lnk_word[g+1] ^ cand_inv[g+1];
    assign lone  = tl ^ th;
    assign opp   = tl & th & (cand[g] ^ cand[g+1]);
    assign opp_i = tl_i & th_i & (cand_inv[g] ^ cand_inv[g+1]);
    assign helps[g] = opp | (lone & ~opp_i);
  end

  always_comb begin
    help_cnt = '0;
    for (int i = 0; i < NPAIR; i++) help_cnt = help_cnt + CW'(helps[i]);
  end

  assign flip = help_cnt > CW'(HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lnk_valid <= 1'b0;
      lnk_word  <= '0;
    end else begin
      lnk_valid <= enc_valid;
      if (enc_valid) lnk_word <= flip ? cand_inv : cand;
    end
  end

  // decoder
  logic [W-2:0] restored;
  assign restored = dec_word[W-2:0] ^ (ODD_LINES[W-2:0] & {(W-1){dec_word[W-1]}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_out_valid <= 1'b0;
      dec_payload   <= '0;
    end else begin
      dec_out_valid <= dec_valid;
      if (dec_valid) dec_payload <= restored;
    end
  end

  p_valid_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> lnk_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |=> (!lnk_valid && $stable(lnk_word)));

  p_even_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> ((lnk_word ^ {1'b0, $past(enc_payload)}) & EVEN_LINES) == '0);

  p_odd_follow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> (lnk_word[W-2:0] ^ $past(enc_payload))
                  == (ODD_LINES[W-2:0] & {(W-1){lnk_word[W-1]}}));

  p_repeat_no_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && ({1'b0, enc_payload} == lnk_word)) |=> !lnk_word[W-1]);

  p_dec_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> (dec_out_valid &&
      (((dec_payload ^ $past(dec_word[W-2:0])) & EVEN_LINES[W-2:0]) == '0)));

  p_dec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (!dec_out_valid && $stable(dec_payload)));

endmodule

// File: tb/link_oddinv_codec_test.sv
module link_oddinv_codec_test;
  localparam int W  = 16;
  localparam int PW = W - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enc_valid;
  logic [PW-1:0] enc_payload;
  logic          lnk_valid;
  logic [W-1:0]  lnk_word;
  logic          dec_valid;
  logic [W-1:0]  dec_word;
  logic          dec_out_valid;
  logic [PW-1:0] dec_payload;

  logic          loop_sel;
  logic          drv_valid;
  logic [W-1:0]  drv_word;

  always #5 clk = ~clk;

  assign dec_valid = loop_sel ? lnk_valid : drv_valid;
  assign dec_word  = loop_sel ? lnk_word  : drv_word;

  link_oddinv_codec #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_payload(enc_payload),
    .lnk_valid(lnk_valid), .lnk_word(lnk_word),
    .dec_valid(dec_valid), .dec_word(dec_word),
    .dec_out_valid(dec_out_valid), .dec_payload(dec_payload)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [W-1:0] ref_prev;

  function automatic logic [W-1:0] odd_set();
    logic [W-1:0] m = '0;
    for (int i = 1; i < W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int pair_cost(logic pl, logic ph, logic cl, logic ch);
    bit tl = (pl != cl);
    bit th = (ph != ch);
    if (tl && th) return (cl != ch) ? 2 : 0;
    if (tl != th) return 1;
    return 0;
  endfunction

  function automatic int helped_pairs(logic [W-1:0] prev, logic [W-1:0] cand);
    logic [W-1:0] alt = cand ^ odd_set();
    int n = 0;
    for (int i = 0; i < W - 1; i++)
      if (pair_cost(prev[i], prev[i+1], alt[i], alt[i+1]) <
          pair_cost(prev[i], prev[i+1], cand[i], cand[i+1])) n++;
    return n;
  endfunction

  function automatic logic [W-1:0] model_enc(logic [W-1:0] prev, logic [PW-1:0] pl);
    logic [W-1:0] cand = {1'b0, pl};
    if (helped_pairs(prev, cand) > (W - 1) / 2) return cand ^ odd_set();
    return cand;
  endfunction

  function automatic logic [PW-1:0] model_dec(logic [W-1:0] wd);
    logic [W-1:0] m = odd_set();
    return wd[W-1] ? (wd[PW-1:0] ^ m[PW-1:0]) : wd[PW-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_one(input logic [PW-1:0] pl, input string tag);
    logic [W-1:0] e;
    e = model_enc(ref_prev, pl);
    @(negedge clk);
    enc_valid = 1'b1; enc_payload = pl;
    @(negedge clk);
    check({tag, " R4 word"}, lnk_word, e);
    check({tag, " R6 flag"}, W'(lnk_word[W-1]), W'(e[W-1]));
    check({tag, " R2 valid"}, W'(lnk_valid), W'(1));
    enc_valid = 1'b0; enc_payload = ~pl;
    @(negedge clk);
    check({tag, " R9 roundtrip"}, W'(dec_payload), W'(pl));
    check({tag, " R2 idle valid"}, W'(lnk_valid), W'(0));
    check({tag, " R7 hold word"}, lnk_word, e);
    ref_prev = e;
  endtask

  task automatic burst(input int n, input bit sparse);
    logic [PW-1:0] pl, p_last, p_prev;
    logic [W-1:0]  e_last;
    pl = '0; p_last = '0; p_prev = '0; e_last = '0;
    for (int k = 0; k < n + 2; k++) begin
      @(negedge clk);
      if (k >= 1 && k <= n) begin
        check("R6 burst word", lnk_word, e_last);
        check("R2 burst valid", W'(lnk_valid), W'(1));
      end
      if (k >= 2) check("R9 burst roundtrip", W'(dec_payload), W'(p_prev));
      p_prev = p_last;
      if (k < n) begin
        if (sparse) pl = p_last ^ PW'(1 << ($urandom % PW)) ^ PW'(1 << ($urandom % PW));
        else        pl = PW'($urandom);
        e_last = model_enc(ref_prev, pl);
        ref_prev = e_last;
        p_last = pl;
        enc_valid = 1'b1; enc_payload = pl;
      end else begin
        enc_valid = 1'b0;
      end
    end
  endtask

  task automatic dec_direct(input logic [W-1:0] wd);
    @(negedge clk);
    drv_valid = 1'b1; drv_word = wd;
    @(negedge clk);
    check("R8 decode", W'(dec_payload), W'(model_dec(wd)));
    check("R8 decode valid", W'(dec_out_valid), W'(1));
    drv_valid = 1'b0; drv_word = ~wd;
    @(negedge clk);
    check("R8 decode hold", W'(dec_payload), W'(model_dec(wd)));
    check("R8 idle valid", W'(dec_out_valid), W'(0));
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; enc_valid = 1'b1; enc_payload = '1;
    loop_sel = 1'b0; drv_valid = 1'b1; drv_word = '1;
    ref_prev = '0;
    repeat (3) @(negedge clk);
    check("R1 reset word", lnk_word, '0);
    check("R1 reset valid", W'(lnk_valid), W'(0));
    check("R1 reset dec", W'(dec_payload), W'(0));
    check("R1 reset dec valid", W'(dec_out_valid), W'(0));
    enc_valid = 1'b0; drv_valid = 1'b0; loop_sel = 1'b1;
    rst_n = 1'b1;

    // R5 directed pair patterns
    send_one('0, "zeros");
    send_one(PW'(16'h5555), "even ones");
    check("R6 even ones inverts", lnk_word, '1);
    send_one(PW'(16'h5555), "repeat");
    send_one(PW'(16'h2AAA), "odd ones");
    send_one('1, "all ones");
    send_one('1, "all ones again");
    send_one(PW'(16'h0001), "single");
    // R7 base kept across a long idle with changing payload
    repeat (5) begin
      @(negedge clk); enc_payload = PW'($urandom);
    end
    send_one(PW'(16'h1234), "after idle");

    for (int i = 0; i < 60; i++) send_one(PW'($urandom), "R5 random");
    burst(400, 1'b0);
    burst(400, 1'b1);

    loop_sel = 1'b0;
    dec_direct(16'h0000);
    dec_direct(16'h8000);
    dec_direct(16'h7FFF);
    dec_direct(16'hFFFF);
    for (int i = 0; i < 20; i++) dec_direct(W'($urandom));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule